// File: doc/BRIEF.md
# Attained-Service Core Ranking Unit

This block measures how much DRAM bank time each core has consumed and converts those figures into a priority rank per core. A memory request scheduler uses the rank. Every clock cycle, each bank reports whether it is busy and, if so, which core it is serving. Each core's running total for the current quantum grows by the number of banks working on its behalf. Quantum length is set through a port.

At the last cycle of a quantum, every core's total is folded into a smoothed history value. The history takes seven eighths of the new quantum and one eighth of the old history. The per-quantum totals then restart from zero.

A sequential sorter then orders the cores by history value. Less attained service gives a better rank (rank 0 is the highest priority). The sorter publishes all the ranks together a fixed number of cycles later. A separate comparator flags a queried request whose waiting time is past a starvation limit. The scheduler can then serve that request ahead of all ranked traffic.

Top module: `srv_rank_unit`

## Requirements
- R1: In every cycle, a core's current-quantum total grows by the number of banks whose busy bit is set and whose owner field (bits `[b*IDW +: IDW]` of `bank_core`) equals that core's index.
- R2: `rank_out` changes only at the commit edge. The commit edge is exactly NUM_CORES clock edges after the quantum-ending edge. At that edge all fields change together and `rank_update` is high for the following cycle only.
- R3: The core with the smaller history value gets the numerically smaller rank. Rank 0 is served first.
- R4: At the quantum-ending edge, history becomes `T - floor(T/8) + floor(H/8)`, where T is the quantum total including that last cycle and H is the old history. The quantum total then restarts at 0.
- R5: Cores with equal history values are ranked in core-index order, so the lower index gets the smaller rank.
- R6: A quantum total saturates at 2^CNT_W-1 instead of wrapping.
- R7: `req_urgent` is 1 exactly when `req_age` is strictly greater than STARVE_CYCLES, in the same cycle.
- R8: After reset, core k holds rank k (field `[k*RW +: RW]` of `rank_out`), `rank_update` is 0, and `rank_out` is always a permutation of 0..NUM_CORES-1.
- R9: A quantum lasts `quantum_len` cycles. Values below NUM_CORES+2 are raised to NUM_CORES+2. The first quantum ends on the quantum_len-th edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| quantum_len | input | QW | Quantum length in cycles |
| bank_busy | input | NUM_BANKS | Bank b is serving a request this cycle |
| bank_core | input | NUM_BANKS*IDW | Owning core index of each bank, packed |
| req_age | input | AGE_W | Waiting time of the queried request |
| req_urgent | output | 1 | Queried request has passed the starvation limit |
| rank_out | output | NUM_CORES*RW | Rank of each core, packed by core index |
| rank_update | output | 1 | Ranks were committed on the last edge |

## Verification
Faults in the accumulators or the history registers stay hidden until the next commit. They then surface as a wrong ordering in `rank_out`, NUM_CORES cycles after a quantum ends. For that reason the stimulus is built so that the orderings differ from one quantum to the next. The phases cover unequal loads, full ties, saturated cores and random traffic. A fault in the quantum counter or the sorter timing shows as a `rank_update` pulse or a rank change in the wrong cycle. These are compared on every clock. The starvation flag is combinational and is checked in the same cycle as each new age, including the values one below and one above the limit.

// File: rtl/srv_pkg.sv
package srv_pkg;
   localparam int SRV_MAX_CORES = 16;
   localparam int SRV_BLEND_SHIFT = 3;

   function automatic int srv_min_quantum(input int ncores);
      return ncores + 2;
   endfunction
endpackage

// File: rtl/srv_quantum.sv
module srv_quantum #(
   parameter int QW = 24,
   parameter int NC = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [QW-1:0] quantum_len,
   output logic          boundary
);
   localparam logic [QW-1:0] MINQ = QW'(srv_pkg::srv_min_quantum(NC));

   logic [QW-1:0] qcnt;
   logic [QW-1:0] eff_len;

   assign eff_len  = (quantum_len < MINQ) ? MINQ : quantum_len;
   assign boundary = (qcnt >= eff_len - QW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n)        qcnt <= '0;
      else if (boundary) qcnt <= '0;
      else               qcnt <= qcnt + QW'(1);
   end
endmodule

// File: rtl/srv_accum.sv
module srv_accum #(
   parameter int NC    = 4,
   parameter int NB    = 4,
   parameter int CNT_W = 24,
   parameter int IDW   = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NB-1:0]       bank_busy,
   input  logic [NB*IDW-1:0]   bank_core,
   input  logic                boundary,
   output logic [NC*CNT_W-1:0] hist_flat
);
   localparam int IW = $clog2(NB + 1);
   localparam logic [CNT_W-1:0] MAXV = '1;

   for (genvar k = 0; k < NC; k++) begin : g_core
      logic [IW-1:0]    inc;
      logic [CNT_W:0]   sum;
      logic [CNT_W-1:0] cur, hist, tot, blend;

      always_comb begin
         inc = '0;
         for (int b = 0; b < NB; b++) begin
            if (bank_busy[b] && (bank_core[b*IDW +: IDW] == IDW'(k)))
               inc = inc + IW'(1);
         end
      end

      assign sum   = {1'b0, cur} + (CNT_W+1)'(inc);
      assign tot   = sum[CNT_W] ? MAXV : sum[CNT_W-1:0];
      assign blend = tot - (tot >> srv_pkg::SRV_BLEND_SHIFT)
                         + (hist >> srv_pkg::SRV_BLEND_SHIFT);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cur  <= '0;
            hist <= '0;
         end else if (boundary) begin
            hist <= blend;
            cur  <= '0;
         end else begin
            cur  <= tot;
         end
      end

      assign hist_flat[k*CNT_W +: CNT_W] = hist;
   end
endmodule

// File: rtl/srv_sorter.sv
module srv_sorter #(
   parameter int NC    = 4,
   parameter int CNT_W = 24,
   parameter int RW    = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [NC*CNT_W-1:0] hist_flat,
   output logic [NC*RW-1:0]    rank_flat,
   output logic                commit
);
   logic          busy;
   logic [RW-1:0] j;
   logic [CNT_W-1:0] hj;
   logic          last;

   assign hj   = hist_flat[j*CNT_W +: CNT_W];
   assign last = (j == RW'(NC - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         j      <= '0;
         commit <= 1'b0;
      end else begin
         commit <= busy && last;
         if (start) begin
            busy <= 1'b1;
            j    <= '0;
         end else if (busy) begin
            if (last) busy <= 1'b0;
            j <= j + RW'(1);
         end
      end
   end

   for (genvar k = 0; k < NC; k++) begin : g_rank
      logic [CNT_W-1:0] hk;
      logic             beat;
      logic [RW-1:0]    cnt, cnt_nx;

      assign hk     = hist_flat[k*CNT_W +: CNT_W];
      assign beat   = (hj < hk) || ((hj == hk) && (j < RW'(k)));
      assign cnt_nx = cnt + RW'(beat);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cnt                  <= '0;
            rank_flat[k*RW +: RW] <= RW'(k);
         end else if (start) begin
            cnt <= '0;
         end else if (busy) begin
            cnt <= cnt_nx;
            if (last) rank_flat[k*RW +: RW] <= cnt_nx;
         end
      end
   end
endmodule

// File: rtl/srv_rank_unit.sv
module srv_rank_unit #(
   parameter int NUM_CORES    = 4,
   parameter int NUM_BANKS    = 8,
   parameter int CNT_W        = 28,
   parameter int QW           = 24,
   parameter int AGE_W        = 20,
   parameter int STARVE_CYCLES = 50000,
   localparam int IDW         = $clog2(NUM_CORES),
   localparam int RW          = IDW
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [QW-1:0]          quantum_len,
   input  logic [NUM_BANKS-1:0]   bank_busy,
   input  logic [NUM_BANKS*IDW-1:0] bank_core,
   input  logic [AGE_W-1:0]       req_age,
   output logic                   req_urgent,
   output logic [NUM_CORES*RW-1:0] rank_out,
   output logic                   rank_update
);
   if (NUM_CORES < 2 || NUM_CORES > srv_pkg::SRV_MAX_CORES)
      $error("NUM_CORES must lie in 2..16");
   if (NUM_BANKS < 1)
      $error("NUM_BANKS must be positive");
   if (CNT_W < 4)
      $error("CNT_W too narrow for the blend shift");
   if (QW < 5 || QW > 31)
      $error("QW out of range");
   if (AGE_W > 31 || STARVE_CYCLES >= (1 << AGE_W))
      $error("STARVE_CYCLES does not fit in AGE_W");

   logic                       boundary;
   logic [NUM_CORES*CNT_W-1:0] hist_flat;

   srv_quantum #(.QW(QW), .NC(NUM_CORES)) u_quant (
      .clk(clk), .rst_n(rst_n), .quantum_len(quantum_len), .boundary(boundary)
   );

   srv_accum #(.NC(NUM_CORES), .NB(NUM_BANKS), .CNT_W(CNT_W), .IDW(IDW)) u_acc (
      .clk(clk), .rst_n(rst_n), .bank_busy(bank_busy), .bank_core(bank_core),
      .boundary(boundary), .hist_flat(hist_flat)
   );

   srv_sorter #(.NC(NUM_CORES), .CNT_W(CNT_W), .RW(RW)) u_sort (
      .clk(clk), .rst_n(rst_n), .start(boundary), .hist_flat(hist_flat),
      .rank_flat(rank_out), .commit(rank_update)
   );

   assign req_urgent = (req_age > AGE_W'(STARVE_CYCLES));
endmodule

// File: rtl/srv_rank_chk.sv
module srv_rank_chk #(
   parameter int NC     = 4,
   parameter int RW     = 2,
   parameter int AGE_W  = 20,
   parameter int STARVE = 50000
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NC*RW-1:0]  rank_out,
   input logic              rank_update,
   input logic [AGE_W-1:0]  req_age,
   input logic              req_urgent
);
   logic [(1<<RW)-1:0] seen;

   always_comb begin
      seen = '0;
      for (int k = 0; k < NC; k++) seen[rank_out[k*RW +: RW]] = 1'b1;
   end

   a_r8_rank_permutation: assert property (@(posedge clk) disable iff (!rst_n)
      (&seen[NC-1:0]));

   a_r2_hold_between_commits: assert property (@(posedge clk) disable iff (!rst_n)
      !rank_update |-> $stable(rank_out));

   a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rank_update |=> !rank_update);

   a_r7_calm_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
      (req_age <= AGE_W'(STARVE)) |-> !req_urgent);

   a_r7_urgent_above_limit: assert property (@(posedge clk) disable iff (!rst_n)
      (req_age > AGE_W'(STARVE)) |-> req_urgent);
endmodule

bind srv_rank_unit srv_rank_chk #(
   .NC(NUM_CORES), .RW(RW), .AGE_W(AGE_W), .STARVE(STARVE_CYCLES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .rank_out(rank_out), .rank_update(rank_update),
   .req_age(req_age), .req_urgent(req_urgent)
);

// File: tb/sim_srv_rank_unit.sv
module sim_srv_rank_unit;
   localparam int NC = 4, NB = 4, CW = 10, QW = 16, AW = 20, ST = 50000;
   localparam int IDW = 2, RW = 2, MAXV = (1 << CW) - 1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [QW-1:0] qlen = 16'd300;
   logic [NB-1:0] bb = '0;
   logic [NB*IDW-1:0] bc = '0;
   logic [AW-1:0] age = '0;
   logic urgent, upd;
   logic [NC*RW-1:0] ranks;

   int tests = 0, fails = 0;
   string tag = "R8";

   always #4 clk = ~clk;

   srv_rank_unit #(.NUM_CORES(NC), .NUM_BANKS(NB), .CNT_W(CW), .QW(QW),
                   .AGE_W(AW), .STARVE_CYCLES(ST)) u0 (
      .clk(clk), .rst_n(rst_n), .quantum_len(qlen), .bank_busy(bb), .bank_core(bc),
      .req_age(age), .req_urgent(urgent), .rank_out(ranks), .rank_update(upd));

   // behavioural reference
   int m_cur[NC], m_hist[NC], m_rank[NC];
   int m_qc, m_timer, m_upd;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < NC; k++) begin
            m_cur[k] = 0; m_hist[k] = 0; m_rank[k] = k;
         end
         m_qc = 0; m_timer = 0; m_upd = 0;
      end else begin
         int inc[NC];
         int lim;
         lim = (int'(qlen) < NC + 2) ? NC + 2 : int'(qlen);
         for (int k = 0; k < NC; k++) inc[k] = 0;
         for (int b = 0; b < NB; b++)
            if (bb[b]) inc[int'(bc[b*IDW +: IDW])]++;
         m_upd = 0;
         if (m_timer > 0) begin
            m_timer--;
            if (m_timer == 0) begin
               for (int k = 0; k < NC; k++) begin
                  int r;
                  r = 0;
                  for (int o = 0; o < NC; o++)
                     if (m_hist[o] < m_hist[k] || (m_hist[o] == m_hist[k] && o < k)) r++;
                  m_rank[k] = r;
               end
               m_upd = 1;
            end
         end
         if (m_qc >= lim - 1) begin
            for (int k = 0; k < NC; k++) begin
               int t;
               t = m_cur[k] + inc[k];
               if (t > MAXV) t = MAXV;
               m_hist[k] = t - t / 8 + m_hist[k] / 8;
               m_cur[k] = 0;
            end
            m_timer = NC;
            m_qc = 0;
         end else begin
            for (int k = 0; k < NC; k++) begin
               m_cur[k] = m_cur[k] + inc[k];
               if (m_cur[k] > MAXV) m_cur[k] = MAXV;
            end
            m_qc++;
         end
      end
   end

   task automatic check_outputs(string rtag);
      for (int k = 0; k < NC; k++) begin
         tests++;
         if (int'(ranks[k*RW +: RW]) != m_rank[k]) begin
            fails++;
            $display("FAIL %s core %0d rank actual %0d expected %0d", rtag, k,
                     ranks[k*RW +: RW], m_rank[k]);
         end
      end
      tests++;
      if (int'(upd) != m_upd) begin
         fails++;
         $display("FAIL R2 rank_update actual %0d expected %0d", upd, m_upd);
      end
   endtask

   task automatic check_urgent();
      tests++;
      if (urgent != (int'(age) > ST)) begin
         fails++;
         $display("FAIL R7 age %0d urgent actual %0d expected %0d", age, urgent,
                  int'(age) > ST);
      end
   endtask

   task automatic drive(int phase, int cyc);
      for (int b = 0; b < NB; b++) begin
         case (phase)
            0: begin // R1 R3: unequal load, core 0 idle
               bb[b] = (b < 2) ? 1'b1 : ($urandom % 2 == 0);
               bc[b*IDW +: IDW] = (b < 2) ? 2'd3 : ((b == 2) ? 2'd2 : 2'd1);
            end
            1: begin // R5: idle, histories decay to ties
               bb[b] = 1'b0; bc[b*IDW +: IDW] = 2'(b);
            end
            2: begin // R6: every bank on core 0, saturating
               bb[b] = 1'b1; bc[b*IDW +: IDW] = 2'd0;
            end
            default: begin // R4 R9: random traffic
               bb[b] = ($urandom % 3 != 0); bc[b*IDW +: IDW] = 2'($urandom % NC);
            end
         endcase
      end
      case (cyc % 50)
         0: age = AW'(ST);
         1: age = AW'(ST + 1);
         2: age = '0;
         3: age = '1;
         4: age = AW'(ST - 1);
         default: age = AW'($urandom % 100000);
      endcase
   endtask

   initial begin
      #(8 * 200000);
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check_outputs("R8"); // reset ranks k, update low
      rst_n = 1'b1;
      for (int phase = 0; phase < 5; phase++) begin
         int len;
         case (phase)
            0: tag = "R1 R3";
            1: tag = "R5";
            2: tag = "R6";
            3: tag = "R4";
            default: tag = "R9";
         endcase
         if (phase == 4) qlen = 16'd3; // below the minimum, raised to NC+2
         len = (phase == 4) ? 300 : 1500;
         for (int c = 0; c < len; c++) begin
            @(negedge clk);
            check_outputs(tag);
            drive(phase, c);
            #1 check_urgent();
         end
      end
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule